// File: doc/BRIEF.md
# Chipset Sleep-State Handshake Sequencer

This block sequences a memory and system controller between full power and two sleep levels: a light sleep (S1), in which the memory keeps its contents in self-refresh and internal clocks are gated, and a deep sleep (S3, suspend to RAM), in which the I/O rings are later isolated and the DDR clocks stop. It does not gate clocks itself and does not build bus cycles. Instead, it drives level request outputs that the processor link logic, the DRAM controller, the PCI cycle generator and the clock-gating cells answer with level acknowledges.

Entry starts with a one-cycle start pulse and a target code. The sequencer first disconnects the processor. It then puts the DRAM into self-refresh. After that it has the stop-grant special cycle issued, and finally it waits for the clock-stop input before gating the clocks. While asleep, a DMA transfer that needs snooping makes the sequencer bring the DRAM and processor back for a probe, after which it goes back to sleep. Processor bus activity makes it wake fully. In deep sleep, a system reset isolates the I/O rings, and the DDR clocks run on for a fixed tail before they stop.

Top module: `sleep_handshake_seq`

## Requirements
- R1: After reset all request outputs, clk_gate_o and io_gate_o are 0, and ddr_clk_en_o is 1.
- R2: A start_i pulse in full-on with target_i equal to 2'b01 (S1) or 2'b11 (S3) raises cpu_disc_o on the next clock. With target_i equal to 2'b00 or 2'b10, a start pulse is ignored, and any start pulse outside full-on is ignored.
- R3: sr_req_o rises only on the clock after cpu_disc_ack_i is seen high. While that acknowledge is held low, sr_req_o stays 0.
- R4: stpgnt_req_o rises only after sr_ack_i is seen high and is held until stpgnt_ack_i is seen. The sequencer then waits for stpgnt_ack_i to return low before it watches clkstop_i.
- R5: clk_gate_o rises on the clock after clkstop_i is seen high in the waiting step. Without clkstop_i it stays 0.
- R6: A snoop_i pulse while asleep (and no cpu_active_i) drops clk_gate_o and sr_req_o on the next clock. cpu_disc_o drops after sr_ack_i returns low. probe_req_o rises after cpu_disc_ack_i returns low and is held until probe_ack_i.
- R7: After a probe acknowledge with cpu_active_i low, the sequencer re-requests disconnect and then self-refresh, and returns to gated sleep without a new stop-grant request.
- R8: cpu_active_i while asleep, or on the probe acknowledge, wins over snoop_i. It releases self-refresh, then the disconnect, and returns to full-on without any probe.
- R9: In S3 sleep, sys_reset_i raises io_gate_o on the next clock. ddr_clk_en_o then stays 1 for exactly TAIL_CYCLES (default 6) more clocks, after which it goes to 0. Both states persist, ignoring other inputs, until rst_n.
- R10: In S1 sleep, sys_reset_i has no effect on io_gate_o or ddr_clk_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin sleep entry |
| target_i | input | 2 | Sleep level: 2'b01 S1, 2'b11 S3 |
| cpu_disc_o | output | 1 | Processor disconnect request (level) |
| cpu_disc_ack_i | input | 1 | Processor is disconnected |
| sr_req_o | output | 1 | DRAM self-refresh request (level) |
| sr_ack_i | input | 1 | DRAM is in self-refresh |
| stpgnt_req_o | output | 1 | Stop-grant special cycle request |
| stpgnt_ack_i | input | 1 | Stop-grant cycle issued |
| clkstop_i | input | 1 | Clock-stop indication from the system |
| snoop_i | input | 1 | DMA transfer needs a processor snoop |
| cpu_active_i | input | 1 | Processor issues non-NOP bus cycles |
| probe_req_o | output | 1 | Probe request on the processor bus |
| probe_ack_i | input | 1 | Probe finished |
| sys_reset_i | input | 1 | System reset asserted (active high) |
| clk_gate_o | output | 1 | Internal clocks gated off |
| io_gate_o | output | 1 | I/O rings isolated |
| ddr_clk_en_o | output | 1 | DDR output clocks enabled |

## Verification
Every output is decoded from the state register. A wrong state therefore shows at the ports on the very next clock, as a request raised before its acknowledge, a missing or extra stop-grant, or a gate that is high while memory is out of self-refresh. The bench stalls each acknowledge to expose premature steps. It drives snoop and processor activity together to check which one wins. It counts the DDR clock tail cycle by cycle, so a tail that is one clock too long or too short shows up as an output mismatch on the clock where it differs.

// File: rtl/shs_pkg.sv
package shs_pkg;
   typedef enum logic [3:0] {
      ST_ON     = 4'd0,
      ST_DISC   = 4'd1,
      ST_SRENT  = 4'd2,
      ST_SGREQ  = 4'd3,
      ST_SGREL  = 4'd4,
      ST_WSTOP  = 4'd5,
      ST_SLEEP  = 4'd6,
      ST_WKSR   = 4'd7,
      ST_WKCONN = 4'd8,
      ST_PROBE  = 4'd9,
      ST_S3TAIL = 4'd10,
      ST_S3OFF  = 4'd11
   } shs_state_e;

   typedef struct packed {
      logic disc;
      logic sr;
      logic sg;
      logic probe;
      logic gate;
      logic iogate;
      logic ddren;
   } shs_drive_t;
endpackage

// File: rtl/shs_tail_timer.sv
module shs_tail_timer #(
   parameter int TAIL_CYCLES = 6,
   localparam int CNT_W = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   generate
      if (TAIL_CYCLES == 1) begin : g_single
         assign done_o = run_i;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(TAIL_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run_i)
               cnt_q <= '0;
            else if (cnt_q != LAST)
               cnt_q <= cnt_q + 1'b1;
         end
         assign done_o = run_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/shs_decode.sv
module shs_decode
   import shs_pkg::*;
(
   input  shs_state_e state_i,
   output shs_drive_t drv_o
);
   always_comb begin
      drv_o = '{default: 1'b0};
      drv_o.ddren = 1'b1;
      unique case (state_i)
         ST_ON, ST_WKCONN: ;
         ST_DISC, ST_WKSR: drv_o.disc = 1'b1;
         ST_SRENT, ST_SGREL, ST_WSTOP: begin
            drv_o.disc = 1'b1;
            drv_o.sr   = 1'b1;
         end
         ST_SGREQ: begin
            drv_o.disc = 1'b1;
            drv_o.sr   = 1'b1;
            drv_o.sg   = 1'b1;
         end
         ST_SLEEP: begin
            drv_o.disc = 1'b1;
            drv_o.sr   = 1'b1;
            drv_o.gate = 1'b1;
         end
         ST_PROBE: drv_o.probe = 1'b1;
         ST_S3TAIL, ST_S3OFF: begin
            drv_o.disc   = 1'b1;
            drv_o.sr     = 1'b1;
            drv_o.gate   = 1'b1;
            drv_o.iogate = 1'b1;
            drv_o.ddren  = (state_i == ST_S3TAIL);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/shs_fsm.sv
module shs_fsm
   import shs_pkg::*;
#(
   parameter logic [1:0] S1_CODE = 2'b01,
   parameter logic [1:0] S3_CODE = 2'b11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [1:0] target_i,
   input  logic       disc_ack_i,
   input  logic       sr_ack_i,
   input  logic       sg_ack_i,
   input  logic       clkstop_i,
   input  logic       snoop_i,
   input  logic       cpu_active_i,
   input  logic       probe_ack_i,
   input  logic       sys_reset_i,
   input  logic       tail_done_i,
   output shs_state_e state_o
);
   shs_state_e state_q, state_d;
   logic deep_q, deep_d;
   logic snp_q, snp_d;
   logic resleep_q, resleep_d;
   logic tgt_ok;

   assign tgt_ok = (target_i == S1_CODE) || (target_i == S3_CODE);

   always_comb begin
      state_d   = state_q;
      deep_d    = deep_q;
      snp_d     = snp_q;
      resleep_d = resleep_q;
      unique case (state_q)
         ST_ON: begin
            resleep_d = 1'b0;
            snp_d     = 1'b0;
            if (start_i && tgt_ok) begin
               deep_d  = (target_i == S3_CODE);
               state_d = ST_DISC;
            end
         end
         ST_DISC:   if (disc_ack_i) state_d = ST_SRENT;
         ST_SRENT:  if (sr_ack_i) state_d = resleep_q ? ST_SLEEP : ST_SGREQ;
         ST_SGREQ:  if (sg_ack_i) state_d = ST_SGREL;
         ST_SGREL:  if (!sg_ack_i) state_d = ST_WSTOP;
         ST_WSTOP:  if (clkstop_i) state_d = ST_SLEEP;
         ST_SLEEP: begin
            if (deep_q && sys_reset_i) begin
               state_d = ST_S3TAIL;
            end else if (cpu_active_i) begin
               snp_d   = 1'b0;
               state_d = ST_WKSR;
            end else if (snoop_i) begin
               snp_d   = 1'b1;
               state_d = ST_WKSR;
            end
         end
         ST_WKSR:   if (!sr_ack_i) state_d = ST_WKCONN;
         ST_WKCONN: if (!disc_ack_i) state_d = snp_q ? ST_PROBE : ST_ON;
         ST_PROBE: begin
            if (probe_ack_i) begin
               snp_d = 1'b0;
               if (cpu_active_i) begin
                  state_d = ST_ON;
               end else begin
                  resleep_d = 1'b1;
                  state_d   = ST_DISC;
               end
            end
         end
         ST_S3TAIL: if (tail_done_i) state_d = ST_S3OFF;
         ST_S3OFF:  ;
         default:   state_d = ST_ON;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_ON;
         deep_q    <= 1'b0;
         snp_q     <= 1'b0;
         resleep_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         deep_q    <= deep_d;
         snp_q     <= snp_d;
         resleep_q <= resleep_d;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/sleep_handshake_seq.sv
module sleep_handshake_seq
   import shs_pkg::*;
#(
   parameter int         TAIL_CYCLES = 6,
   parameter logic [1:0] S1_CODE     = 2'b01,
   parameter logic [1:0] S3_CODE     = 2'b11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [1:0] target_i,
   output logic       cpu_disc_o,
   input  logic       cpu_disc_ack_i,
   output logic       sr_req_o,
   input  logic       sr_ack_i,
   output logic       stpgnt_req_o,
   input  logic       stpgnt_ack_i,
   input  logic       clkstop_i,
   input  logic       snoop_i,
   input  logic       cpu_active_i,
   output logic       probe_req_o,
   input  logic       probe_ack_i,
   input  logic       sys_reset_i,
   output logic       clk_gate_o,
   output logic       io_gate_o,
   output logic       ddr_clk_en_o
);
   generate
      if (TAIL_CYCLES < 1) begin : g_bad_tail
         initial $error("sleep_handshake_seq: TAIL_CYCLES must be at least 1");
      end
      if (S1_CODE == S3_CODE) begin : g_bad_codes
         initial $error("sleep_handshake_seq: S1_CODE and S3_CODE must differ");
      end
   endgenerate

   shs_state_e state;
   shs_drive_t drv;
   logic       tail_done;

   shs_fsm #(.S1_CODE(S1_CODE), .S3_CODE(S3_CODE)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .target_i     (target_i),
      .disc_ack_i   (cpu_disc_ack_i),
      .sr_ack_i     (sr_ack_i),
      .sg_ack_i     (stpgnt_ack_i),
      .clkstop_i    (clkstop_i),
      .snoop_i      (snoop_i),
      .cpu_active_i (cpu_active_i),
      .probe_ack_i  (probe_ack_i),
      .sys_reset_i  (sys_reset_i),
      .tail_done_i  (tail_done),
      .state_o      (state)
   );

   shs_tail_timer #(.TAIL_CYCLES(TAIL_CYCLES)) u_tail (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == ST_S3TAIL),
      .done_o (tail_done)
   );

   shs_decode u_dec (
      .state_i (state),
      .drv_o   (drv)
   );

   assign cpu_disc_o   = drv.disc;
   assign sr_req_o     = drv.sr;
   assign stpgnt_req_o = drv.sg;
   assign probe_req_o  = drv.probe;
   assign clk_gate_o   = drv.gate;
   assign io_gate_o    = drv.iogate;
   assign ddr_clk_en_o = drv.ddren;
endmodule

// File: rtl/sleep_handshake_seq_chk.sv
module sleep_handshake_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cpu_disc_o,
   input logic cpu_disc_ack_i,
   input logic sr_req_o,
   input logic sr_ack_i,
   input logic stpgnt_req_o,
   input logic stpgnt_ack_i,
   input logic probe_req_o,
   input logic clk_gate_o,
   input logic io_gate_o,
   input logic ddr_clk_en_o
);
   assert_sr_after_disc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_req_o) |-> $past(cpu_disc_ack_i));

   assert_sg_after_sr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stpgnt_req_o) |-> $past(sr_ack_i));

   assert_sg_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stpgnt_req_o && !stpgnt_ack_i) |=> stpgnt_req_o);

   assert_gate_in_sr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clk_gate_o |-> (sr_req_o && cpu_disc_o));

   assert_probe_connected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req_o |-> (!cpu_disc_o && !sr_req_o));

   assert_ddr_stop_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ddr_clk_en_o) |-> io_gate_o);

   assert_io_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      io_gate_o |=> io_gate_o);
endmodule

bind sleep_handshake_seq sleep_handshake_seq_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_disc_o     (cpu_disc_o),
   .cpu_disc_ack_i (cpu_disc_ack_i),
   .sr_req_o       (sr_req_o),
   .sr_ack_i       (sr_ack_i),
   .stpgnt_req_o   (stpgnt_req_o),
   .stpgnt_ack_i   (stpgnt_ack_i),
   .probe_req_o    (probe_req_o),
   .clk_gate_o     (clk_gate_o),
   .io_gate_o      (io_gate_o),
   .ddr_clk_en_o   (ddr_clk_en_o)
);

// File: tb/sleep_handshake_seq_tb_top.sv
`timescale 1ns/1ps
module sleep_handshake_seq_tb_top;
   localparam int TAIL = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] target = 2'b00;
   logic disc, disc_ack = 1'b0;
   logic sr, sr_ack = 1'b0;
   logic sg, sg_ack = 1'b0;
   logic clkstop = 1'b0, snoop = 1'b0, cpu_act = 1'b0;
   logic probe, probe_ack = 1'b0;
   logic sysrst = 1'b0;
   logic gate, iog, ddren;

   logic stall_disc = 1'b0, stall_sr = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;
   string tag = "R1";

   always #5 clk = ~clk;

   sleep_handshake_seq #(.TAIL_CYCLES(TAIL)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
      .cpu_disc_o(disc), .cpu_disc_ack_i(disc_ack),
      .sr_req_o(sr), .sr_ack_i(sr_ack),
      .stpgnt_req_o(sg), .stpgnt_ack_i(sg_ack),
      .clkstop_i(clkstop), .snoop_i(snoop), .cpu_active_i(cpu_act),
      .probe_req_o(probe), .probe_ack_i(probe_ack),
      .sys_reset_i(sysrst),
      .clk_gate_o(gate), .io_gate_o(iog), .ddr_clk_en_o(ddren)
   );

   // Responders: each acknowledge follows its request one clock later.
   always @(negedge clk) begin
      if (!stall_disc) disc_ack = disc;
      if (!stall_sr)   sr_ack   = sr;
      sg_ack    = sg;
      probe_ack = probe;
   end

   // Behavioural reference: phase names describe what the system waits on.
   localparam int P_AWAKE = 0, P_WANT_DISC = 1, P_WANT_SR = 2, P_WANT_SG = 3,
                  P_SG_DROP = 4, P_WANT_STOP = 5, P_ASLEEP = 6, P_LEAVE_SR = 7,
                  P_RECONNECT = 8, P_PROBING = 9, P_TAIL = 10, P_DEAD = 11;
   int  m_phase = P_AWAKE;
   bit  m_deep = 1'b0, m_for_probe = 1'b0, m_back = 1'b0;
   int  m_tail = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = P_AWAKE; m_deep = 0; m_for_probe = 0; m_back = 0; m_tail = 0;
      end else begin
         case (m_phase)
            P_AWAKE: begin
               m_back = 0; m_for_probe = 0;
               if (start && (target == 2'b01 || target == 2'b11)) begin
                  m_deep = (target == 2'b11); m_phase = P_WANT_DISC;
               end
            end
            P_WANT_DISC: if (disc_ack) m_phase = P_WANT_SR;
            P_WANT_SR:   if (sr_ack) m_phase = m_back ? P_ASLEEP : P_WANT_SG;
            P_WANT_SG:   if (sg_ack) m_phase = P_SG_DROP;
            P_SG_DROP:   if (!sg_ack) m_phase = P_WANT_STOP;
            P_WANT_STOP: if (clkstop) m_phase = P_ASLEEP;
            P_ASLEEP: begin
               if (m_deep && sysrst) begin m_phase = P_TAIL; m_tail = TAIL; end
               else if (cpu_act) begin m_for_probe = 0; m_phase = P_LEAVE_SR; end
               else if (snoop) begin m_for_probe = 1; m_phase = P_LEAVE_SR; end
            end
            P_LEAVE_SR:  if (!sr_ack) m_phase = P_RECONNECT;
            P_RECONNECT: if (!disc_ack) m_phase = m_for_probe ? P_PROBING : P_AWAKE;
            P_PROBING: if (probe_ack) begin
               m_for_probe = 0;
               if (cpu_act) m_phase = P_AWAKE;
               else begin m_back = 1; m_phase = P_WANT_DISC; end
            end
            P_TAIL: begin
               if (m_tail == 1) m_phase = P_DEAD;
               else m_tail = m_tail - 1;
            end
            default: ;
         endcase
      end
   end

   // expected {disc, sr, sg, probe, gate, io, ddr}
   function automatic logic [6:0] expect_out(int p);
      case (p)
         P_WANT_DISC, P_LEAVE_SR:            return 7'b1000001;
         P_WANT_SR, P_SG_DROP, P_WANT_STOP:  return 7'b1100001;
         P_WANT_SG:                          return 7'b1110001;
         P_ASLEEP:                           return 7'b1100101;
         P_PROBING:                          return 7'b0001001;
         P_TAIL:                             return 7'b1100111;
         P_DEAD:                             return 7'b1100110;
         default:                            return 7'b0000001;
      endcase
   endfunction

   task automatic check(input string t, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at cycle %0d", t, act, exp, cycles);
      end
   endtask

   function automatic logic [6:0] outs();
      return {disc, sr, sg, probe, gate, iog, ddren};
   endfunction

   always @(negedge clk) begin
      if (rst_n && model_on && !done) check({tag, " model"}, outs(), expect_out(m_phase));
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start(input logic [1:0] t);
      @(negedge clk); target = t; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_gate_high();
      for (int i = 0; i < 60; i++) begin
         if (gate) break;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      int sg_seen, pr_seen, ddr_cnt;
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      tag = "R1";
      check("R1 reset outputs", outs(), 7'b0000001);
      model_on = 1'b1;

      // R2: invalid targets ignored
      tag = "R2";
      pulse_start(2'b00); tick(3);
      check("R2 target 00 ignored", outs(), 7'b0000001);
      pulse_start(2'b10); tick(3);
      check("R2 target 10 ignored", outs(), 7'b0000001);

      // R3: stall disconnect acknowledge
      tag = "R3";
      stall_disc = 1'b1;
      pulse_start(2'b01);
      tick(4);
      check("R3 sr waits for disc ack", outs(), 7'b1000001);
      // R2: start while not full-on is ignored
      tag = "R2";
      pulse_start(2'b11);
      check("R2 start outside full-on", outs(), 7'b1000001);
      tag = "R4";
      stall_sr = 1'b1;
      stall_disc = 1'b0;
      tick(4);
      check("R4 sg waits for sr ack", outs(), 7'b1100001);
      stall_sr = 1'b0;
      tick(8);
      tag = "R5";
      check("R5 no gate without clkstop", outs(), 7'b1100001);
      clkstop = 1'b1;
      tick(2);
      check("R5 gate after clkstop", outs(), 7'b1100101);

      // R10: reset in S1 ignored
      tag = "R10";
      sysrst = 1'b1; tick(8);
      check("R10 S1 ignores sys reset", outs(), 7'b1100101);
      sysrst = 1'b0; tick(1);

      // R6/R7: snoop probe and return to sleep
      tag = "R6";
      snoop = 1'b1; @(negedge clk); snoop = 1'b0;
      check("R6 ungate and release sr", outs(), 7'b1000001);
      sg_seen = 0; pr_seen = 0;
      for (int i = 0; i < 60; i++) begin
         if (sg) sg_seen++;
         if (probe) pr_seen++;
         if (pr_seen > 0 && gate) break;
         @(negedge clk);
      end
      checks++;
      if (pr_seen == 0) begin errors++; $display("FAIL R6: probe actual=0 expected=1"); end
      tag = "R7";
      checks++;
      if (sg_seen != 0) begin errors++; $display("FAIL R7: stop-grant cycles actual=%0d expected=0", sg_seen); end
      check("R7 back asleep", outs(), 7'b1100101);

      // R8: processor activity wakes fully
      tag = "R8";
      cpu_act = 1'b1; @(negedge clk); cpu_act = 1'b0;
      tick(8);
      clkstop = 1'b0;
      check("R8 full-on after activity", outs(), 7'b0000001);

      // S3 entry, then snoop and activity together: activity wins
      pulse_start(2'b11);
      tick(8); clkstop = 1'b1;
      wait_gate_high();
      check("R5 S3 asleep", outs(), 7'b1100101);
      snoop = 1'b1; cpu_act = 1'b1; @(negedge clk); snoop = 1'b0; cpu_act = 1'b0;
      pr_seen = 0;
      for (int i = 0; i < 10; i++) begin
         if (probe) pr_seen++;
         @(negedge clk);
      end
      checks++;
      if (pr_seen != 0) begin errors++; $display("FAIL R8: probe cycles actual=%0d expected=0", pr_seen); end
      check("R8 priority full-on", outs(), 7'b0000001);
      clkstop = 1'b0;

      // R9: S3 reset and DDR clock tail
      tag = "R9";
      pulse_start(2'b11);
      tick(8); clkstop = 1'b1;
      wait_gate_high();
      sysrst = 1'b1; @(negedge clk);
      check("R9 io isolated", {iog, ddren}, 2'b11);
      ddr_cnt = 0;
      for (int i = 0; i < 10; i++) begin
         if (ddren) ddr_cnt++;
         @(negedge clk);
      end
      checks++;
      if (ddr_cnt != TAIL) begin errors++; $display("FAIL R9: ddr tail actual=%0d expected=%0d", ddr_cnt, TAIL); end
      sysrst = 1'b0;
      cpu_act = 1'b1; snoop = 1'b1; tick(3); cpu_act = 1'b0; snoop = 1'b0;
      tick(2);
      check("R9 deep state holds", outs(), 7'b1100110);
      finish_run();
   end
endmodule